// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one data word at a time into an asynchronous serial frame on a single output line that rests high. A frame is a low start bit, then the data bits with the least significant first, then an optional parity bit, then a high stop period. Bit timing comes from a one-cycle sub-tick pulse supplied at sixteen times the bit rate, so one bit lasts 16 sub-ticks. That grain also lets the stop period be one and a half bits long.

The frame shape is chosen at run time through three plain two-bit codes. Data length: 0 = 7 bits, 1 = 8 bits, 2 = 9 bits, 3 = 8 bits. Parity: 0 = none, 1 = even, 2 = odd, 3 = none. Stop length: 0 = 1 bit, 1 = 1.5 bits, 2 = 2 bits, 3 = 1 bit. Words enter through a valid/ready handshake. A word is taken on a rising clock edge where both `in_valid` and `in_ready` are high. The data and all three codes are captured at that edge. A producer facing a low `in_ready` must hold its word and keep `in_valid` high; nothing is lost by waiting.

A clear-to-send input `cts_ok` only permits or holds back the start of a new frame. When it is low, `in_ready` stays low and no word is taken. Once a word has been taken, its frame always runs to the end, whatever `cts_ok` does.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1 and `busy` is 0.
- R2: Each frame opens with `tx_line` low for exactly 16 sub-ticks. This start bit begins on the first sub-tick after acceptance.
- R3: After the start bit, the data bits follow, 16 sub-ticks each, with bit 0 first. The count of data bits is set by the length code (0 = 7, 1 = 8, 2 = 9). Input bits above the selected length are not sent. For example, 0x41 in 8-bit mode sends 1,0,0,0,0,0,1,0.
- R4: The parity code sets the parity bit (1 = even, 2 = odd, 0 = none). In even mode, one bit follows the last data bit and makes the count of ones over data plus parity even. In odd mode that count is odd. In none mode no bit is inserted.
- R5: After the last data or parity bit, `tx_line` is high for 16, 24 or 32 sub-ticks, for stop codes 0, 1 and 2. `busy` then falls.
- R6: A frame with 8 data bits, no parity and one stop bit lasts exactly 160 sub-ticks, measured from the start of the start bit to the fall of `busy`.
- R7: `in_ready` is high only when the block is idle and `cts_ok` is high. It goes low in the cycle after acceptance and returns only once the last stop sub-tick has elapsed.
- R8: While `cts_ok` is low, no word is taken and no frame begins. A frame already started completes unchanged if `cts_ok` falls during it.
- R9: Data and format codes are captured at acceptance. Changing them while a frame is in progress does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_len | input | 2 | Data length code: 0 = 7, 1 = 8, 2 = 9 bits |
| cfg_par | input | 2 | Parity code: 0 = none, 1 = even, 2 = odd |
| cfg_stop | input | 2 | Stop length code: 0 = 1, 1 = 1.5, 2 = 2 bits |
| cts_ok | input | 1 | High when a new frame may begin |
| in_valid | input | 1 | Producer has a word |
| in_ready | output | 1 | Block will take a word at this edge |
| in_data | input | MAX_DATA | Word to send, bit 0 first |
| tx_line | output | 1 | Serial line, high when idle |
| busy | output | 1 | High from acceptance to end of stop period |

## Verification
The bench builds the block with its defaults: a 9-bit data path and 16 sub-ticks per bit. It feeds `sub_tick` once every four clocks, so one bit is 64 clocks and a whole frame fits in under a thousand cycles. These values bring every data length, parity mode and stop length within reach, including the 24-sub-tick stop period and a 9-bit word with parity. The line is sampled at bit centres and the fall of `busy` is timed to the clock. This exposes off-by-one sub-tick errors, a wrong bit order, a wrong parity sense, and a frame that reacts to `cts_ok` or to configuration changes after it has started.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_START = 3'd2,
    ST_PAY   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  localparam logic [1:0] PAR_NONE = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  localparam logic [1:0] LEN_SHORT = 2'd0;
  localparam logic [1:0] LEN_MID   = 2'd1;
  localparam logic [1:0] LEN_LONG  = 2'd2;

  localparam logic [1:0] STOP_ONE  = 2'd0;
  localparam logic [1:0] STOP_HALF = 2'd1;
  localparam logic [1:0] STOP_TWO  = 2'd2;

endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int MAX_DATA = 9,
  parameter int OSR      = 16,
  parameter int PW       = MAX_DATA + 1,
  parameter int NW       = $clog2(PW + 1),
  parameter int SW       = $clog2(2 * OSR + 1)
) (
  input  logic [MAX_DATA-1:0] data,
  input  logic [1:0]          len_code,
  input  logic [1:0]          par_code,
  input  logic [1:0]          stop_code,
  output logic [PW-1:0]       payload,
  output logic [NW-1:0]       payload_bits,
  output logic [SW-1:0]       stop_subs
);

  logic [NW-1:0]       n_data;
  logic [MAX_DATA-1:0] masked;
  logic                par_on;
  logic                par_bit;

  always_comb begin
    case (len_code)
      LEN_SHORT: n_data = NW'(MAX_DATA - 2);
      LEN_MID:   n_data = NW'(MAX_DATA - 1);
      LEN_LONG:  n_data = NW'(MAX_DATA);
      default:   n_data = NW'(MAX_DATA - 1);
    endcase
  end

  // keep only the selected low bits of the word
  always_comb begin
    masked = '0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (NW'(i) < n_data) masked[i] = data[i];
    end
  end

  assign par_on  = (par_code == PAR_EVEN) || (par_code == PAR_ODD);
  assign par_bit = (par_code == PAR_ODD) ? ~(^masked) : (^masked);

  // parity lands right after the last data bit
  always_comb begin
    payload = '0;
    payload[MAX_DATA-1:0] = masked;
    if (par_on) payload[n_data] = par_bit;
  end

  assign payload_bits = n_data + NW'(par_on);

  always_comb begin
    case (stop_code)
      STOP_ONE:  stop_subs = SW'(OSR);
      STOP_HALF: stop_subs = SW'(OSR + OSR / 2);
      STOP_TWO:  stop_subs = SW'(2 * OSR);
      default:   stop_subs = SW'(OSR);
    endcase
  end

endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int OSR = 16,
  parameter int SW  = $clog2(2 * OSR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          sub_tick,
  input  logic [SW-1:0] limit,
  output logic          phase_end
);

  logic [SW-1:0] cnt;

  assign phase_end = run && sub_tick && (cnt == limit - SW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (sub_tick) begin
      cnt <= phase_end ? '0 : cnt + SW'(1);
    end
  end

  // R5: the sub-tick count never passes the current phase length
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int MAX_DATA = 9,
  parameter int OSR      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sub_tick,
  input  logic [1:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic [1:0]          cfg_stop,
  input  logic                cts_ok,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_DATA-1:0] in_data,
  output logic                tx_line,
  output logic                busy
);

  localparam int PW = MAX_DATA + 1;
  localparam int NW = $clog2(PW + 1);
  localparam int SW = $clog2(2 * OSR + 1);

  tx_state_e     state;
  logic [PW-1:0] shreg;
  logic [NW-1:0] bits_left;
  logic [SW-1:0] stop_q;

  logic [PW-1:0] f_payload;
  logic [NW-1:0] f_bits;
  logic [SW-1:0] f_stop;
  logic          accept;
  logic          run;
  logic          phase_end;
  logic [SW-1:0] limit;

  uart_tx_framer #(
    .MAX_DATA(MAX_DATA), .OSR(OSR), .PW(PW), .NW(NW), .SW(SW)
  ) u_framer (
    .data         (in_data),
    .len_code     (cfg_len),
    .par_code     (cfg_par),
    .stop_code    (cfg_stop),
    .payload      (f_payload),
    .payload_bits (f_bits),
    .stop_subs    (f_stop)
  );

  assign run   = (state == ST_START) || (state == ST_PAY) || (state == ST_STOP);
  assign limit = (state == ST_STOP) ? stop_q : SW'(OSR);

  uart_tx_bit_timer #(.OSR(OSR), .SW(SW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sub_tick  (sub_tick),
    .limit     (limit),
    .phase_end (phase_end)
  );

  assign in_ready = (state == ST_IDLE) && cts_ok;
  assign accept   = in_valid && in_ready;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    case (state)
      ST_START: tx_line = 1'b0;
      ST_PAY:   tx_line = shreg[0];
      default:  tx_line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bits_left <= '0;
      stop_q    <= SW'(OSR);
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          shreg     <= f_payload;
          bits_left <= f_bits;
          stop_q    <= f_stop;
          state     <= ST_ARM;
        end
        ST_ARM: if (sub_tick) state <= ST_START;
        ST_START: if (phase_end) state <= ST_PAY;
        ST_PAY: if (phase_end) begin
          shreg     <= {1'b0, shreg[PW-1:1]};
          bits_left <= bits_left - NW'(1);
          if (bits_left == NW'(1)) state <= ST_STOP;
        end
        ST_STOP: if (phase_end) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: line rests high outside a frame
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  // R7: no word is offered while a frame is held
  a_r7_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R8: a frame only begins from a cleared-to-send acceptance
  a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cts_ok));

  // R5: a frame ends only by leaving its stop period
  a_r5_end_via_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(state) == ST_STOP));

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

  localparam int BITC = 64;  // clocks per bit: 16 sub-ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_tick;
  logic [1:0] cfg_len = 2'd1, cfg_par = 2'd0, cfg_stop = 2'd0;
  logic       cts_ok = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic       tx_line, busy;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [1:0] div = '0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) div <= div + 2'd1;
  assign sub_tick = (div == 2'd3);

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
    .cts_ok(cts_ok), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tx_line(tx_line), .busy(busy)
  );

  // {data[8:0], len, par, stop}
  localparam logic [14:0] VEC [8] = '{
    {9'h041, 2'd1, 2'd0, 2'd0},
    {9'h0A5, 2'd1, 2'd1, 2'd0},
    {9'h0A5, 2'd1, 2'd2, 2'd0},
    {9'h07F, 2'd0, 2'd1, 2'd1},
    {9'h155, 2'd2, 2'd0, 2'd2},
    {9'h1FF, 2'd2, 2'd2, 2'd1},
    {9'h000, 2'd0, 2'd2, 2'd2},
    {9'h1C3, 2'd1, 2'd0, 2'd0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sends one word and checks the line; returns the clock index of busy falling
  task automatic run_frame(input logic [8:0] d, input logic [1:0] l,
                           input logic [1:0] p, input logic [1:0] s,
                           input bit disturb, output int fall_i);
    int nd, nb, stop_subs, ones;
    logic [11:0] exp_bits, got_bits;
    bit stop_ok;
    int t;
    nd = 7 + ((l == 2'd0) ? 0 : (l == 2'd1) ? 1 : (l == 2'd2) ? 2 : 1);
    exp_bits = '0;
    ones = 0;
    for (int k = 0; k < nd; k++) begin
      exp_bits[k] = d[k];
      ones += d[k];
    end
    nb = nd;
    if (p == 2'd1) begin exp_bits[nd] = ones[0];  nb++; end
    if (p == 2'd2) begin exp_bits[nd] = ~ones[0]; nb++; end
    stop_subs = (s == 2'd1) ? 24 : (s == 2'd2) ? 32 : 16;
    fall_i = -1;

    @(negedge clk);
    in_data = d; cfg_len = l; cfg_par = p; cfg_stop = s; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0 && busy == 1'b1, "R7", "ready after accept",
          in_ready, 0);
    if (disturb) begin
      cts_ok = 1'b0;
      in_data = ~d; cfg_len = 2'd2; cfg_par = 2'd2; cfg_stop = 2'd2;
      in_valid = 1'b1;
    end
    t = 0;
    while (tx_line && t < 200) begin @(negedge clk); t++; end
    check(t <= 5, "R2", "start delay", t, 4);
    if (t >= 200) return;
    got_bits = '0;
    stop_ok = 1;
    for (int i = 0; i < 4000; i++) begin
      if (i > 0) @(negedge clk);
      if (i == BITC - 1)
        check(tx_line == 1'b0, "R2", "start bit low at end", tx_line, 0);
      for (int k = 0; k < nb; k++)
        if (i == BITC * (k + 1) + BITC / 2) got_bits[k] = tx_line;
      if (i >= BITC * (1 + nb) && busy && !tx_line) stop_ok = 0;
      if (!busy) begin fall_i = i; break; end
    end
    check(got_bits == exp_bits, "R3 R4", "payload bits",
          int'(got_bits), int'(exp_bits));
    check(stop_ok, "R5", "stop level high", 0, 1);
    check(fall_i == BITC * (1 + nb) + 4 * stop_subs, "R5", "frame end clock",
          fall_i, BITC * (1 + nb) + 4 * stop_subs);
    check(tx_line == 1'b1, "R1", "line high after frame", tx_line, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int fi;
    repeat (3) @(negedge clk);
    check(tx_line == 1'b1 && busy == 1'b0, "R1", "reset line/busy",
          {tx_line, busy}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R7", "ready idle", in_ready, 1);

    for (int v = 0; v < 8; v++) begin
      run_frame(VEC[v][14:6], VEC[v][5:4], VEC[v][3:2], VEC[v][1:0], 1'b0, fi);
      if (v == 0) check(fi == 640, "R6", "8N1 length in clocks", fi, 640);
    end

    // R8: held back while not cleared to send
    cts_ok = 1'b0;
    in_data = 9'h033; cfg_len = 2'd1; cfg_par = 2'd0; cfg_stop = 2'd0;
    in_valid = 1'b1;
    begin
      bit moved = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (!tx_line || busy || in_ready) moved = 1;
      end
      check(!moved, "R8", "no frame while cts low", moved, 0);
    end
    cts_ok = 1'b1;
    run_frame(9'h033, 2'd1, 2'd0, 2'd0, 1'b0, fi);

    // R8 R9: cts falls and config changes mid-frame; frame unchanged
    run_frame(9'h0B6, 2'd1, 2'd1, 2'd1, 1'b1, fi);
    begin
      bit moved = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (!tx_line || busy || in_ready) moved = 1;
      end
      check(!moved, "R8", "pending word held after frame", moved, 0);
    end
    in_valid = 1'b0;
    cts_ok = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R7", "ready returns", in_ready, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule